// File: doc/BRIEF.md
# Configurable Color Space Converter

This block converts a stream of three-component pixels from one color space to another. Each output component is a weighted sum of the three input components plus a constant. The weights form a 3×3 matrix and the constants form an offset vector. Pixels arrive on a valid/data input and leave on a valid/data output after a fixed number of cycles. After reset the matrix holds a built-in full-range RGB to YCbCr set. A host can rewrite any weight or offset at run time through a one-cycle write strobe with an address and a data word. The datapath only picks up a rewrite at a pixel boundary, so no pixel is computed with a mix of old and new values.

A build parameter `SHARED` selects the datapath:
- With `SHARED` = 0, nine multipliers take one pixel per clock.
- With `SHARED` = 1, three multipliers compute one output row per clock. Each pixel then takes three core cycles, and the input ready signal throttles the source to one pixel in three clocks.

A second parameter, `PIPE_STAGES`, inserts register stages between the dot products and the rounding stage. It changes only the latency, never the values.

Top module: `csc_core`

## Requirements
- R1: After reset the matrix holds these coefficients (row-major, row r column c at index 3r+c): 306, 601, 117, -173, -339, 512, 512, -429, -83. The offsets are 0, 128, 128.
- R2: Component k of a pixel occupies bits [8k+7:8k] and is unsigned.
  - Output component r = clamp(floor((Σc coef[3r+c]·in[c] + off[r]·1024 + 512) / 1024), 0, 255).
  - Coefficients are signed 12-bit values with 10 fraction bits. Offsets are signed 9-bit integers.
- R3: A host write with `cfg_wr` high sets a value as follows:
  - Addresses 0 to 8 set coefficient `cfg_addr` from `cfg_data[11:0]`.
  - Addresses 9 to 11 set offset `cfg_addr`-9 from `cfg_data[8:0]`.
  - The new value applies to every pixel accepted three or more cycles after the write cycle, provided no pixel is then in computation.
- R4: A write to addresses 12 to 15 changes no coefficient and no offset.
- R5: With `SHARED` = 0, `in_ready` stays high in every cycle once out of reset, and a pixel is accepted in every cycle that `in_valid` is high.
- R6: With `SHARED` = 1, after a pixel is accepted `in_ready` is low for the next two cycles and high in the third.
- R7: With `SHARED` = 1, a write issued while a pixel is in computation does not affect that pixel. The next pixel uses the new value.
- R8: A pixel accepted in cycle t appears with `out_valid` high in cycle t+L, with exactly one output per accepted pixel and in input order. L = 2+`PIPE_STAGES` when `SHARED` = 0, and L = 4+`PIPE_STAGES` when `SHARED` = 1.
- R9: The output values do not depend on `PIPE_STAGES` or on `SHARED`.
- R10: While `rst_n` is low, `out_valid` and `in_ready` are low. `in_ready` is high by the third rising clock edge after `rst_n` rises.
- R11: Results below 0 saturate to 0, results above 255 saturate to 255, and halves round upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Core accepts a pixel this cycle |
| in_pix | input | 24 | Input pixel, component k in bits [8k+7:8k] |
| cfg_wr | input | 1 | Host write strobe |
| cfg_addr | input | 4 | Host write address (0-8 coefficients, 9-11 offsets) |
| cfg_data | input | 12 | Host write data |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 24 | Converted pixel, component k in bits [8k+7:8k] |

## Verification
A wrong row select in the shared datapath, or a stale shadow-to-active copy, shows as a wrong component value on the first output of the affected pixel, L cycles after its acceptance. A wrong phase counter shows within three cycles as a wrong `in_ready` rhythm, and later as missing or extra output beats. A broken delay line shows as an output one cycle early or late, or out of order against the input sequence. Running a shared and a parallel instance, at different pipeline depths, against the same arithmetic model exposes a fault in either datapath on the first pixel that exercises it.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int PIX_W  = 8;
  localparam int NCOMP  = 3;
  localparam int NCOEF  = NCOMP * NCOMP;
  localparam int COEF_W = 12;
  localparam int FRAC_W = 10;
  localparam int OFS_W  = 9;
  localparam int ADDR_W = 4;
  localparam int SUM_W  = PIX_W + 1 + COEF_W + 3;
  localparam int PH_W   = $clog2(NCOMP);

  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [OFS_W-1:0]  ofs_t;
  typedef logic [NCOMP-1:0][PIX_W-1:0] pix_t;
  typedef logic [NCOMP-1:0][SUM_W-1:0] sums_t;

  typedef struct packed {
    coef_t [NCOEF-1:0] m;
    ofs_t  [NCOMP-1:0] o;
  } matrix_t;

  // Full-range RGB to YCbCr, weights scaled by 2^FRAC_W
  function automatic matrix_t default_matrix();
    matrix_t d;
    d.m[0] = 12'sd306;   d.m[1] = 12'sd601;   d.m[2] = 12'sd117;
    d.m[3] = -12'sd173;  d.m[4] = -12'sd339;  d.m[5] = 12'sd512;
    d.m[6] = 12'sd512;   d.m[7] = -12'sd429;  d.m[8] = -12'sd83;
    d.o[0] = 9'sd0;      d.o[1] = 9'sd128;    d.o[2] = 9'sd128;
    return d;
  endfunction

  function automatic int conv_latency(bit shared, int pipe);
    return (shared ? 4 : 2) + pipe;
  endfunction
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  input  logic              apply,
  output matrix_t           active_o
);
  localparam matrix_t RESET_M = default_matrix();

  matrix_t shadow_q, shadow_d;
  matrix_t active_q, active_d;

  always_comb begin
    shadow_d = shadow_q;
    for (int i = 0; i < NCOEF; i++)
      if (wr_en && wr_addr == ADDR_W'(i)) shadow_d.m[i] = wr_data;
    for (int j = 0; j < NCOMP; j++)
      if (wr_en && wr_addr == ADDR_W'(NCOEF + j)) shadow_d.o[j] = wr_data[OFS_W-1:0];
  end

  always_comb begin
    active_d = active_q;
    if (apply) active_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RESET_M;
      active_q <= RESET_M;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  assign active_o = active_q;

  // R4
  ignored_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= ADDR_W'(NCOEF + NCOMP)) |=> $stable(shadow_q));
endmodule

// File: rtl/csc_dot.sv
module csc_dot
  import csc_pkg::*;
(
  input  pix_t                     pix_i,
  input  coef_t [NCOMP-1:0]        row_i,
  input  ofs_t                     ofs_i,
  output logic signed [SUM_W-1:0]  sum_o
);
  logic signed [SUM_W-1:0] prod [NCOMP];

  for (genvar k = 0; k < NCOMP; k++) begin : g_mul
    logic signed [SUM_W-1:0] xe, ce;
    assign xe = SUM_W'($signed({1'b0, pix_i[k]}));
    assign ce = SUM_W'($signed(row_i[k]));
    assign prod[k] = xe * ce;
  end

  always_comb begin
    sum_o = SUM_W'(ofs_i) <<< FRAC_W;
    for (int k = 0; k < NCOMP; k++) sum_o = sum_o + prod[k];
  end
endmodule

// File: rtl/csc_round_sat.sv
module csc_round_sat
  import csc_pkg::*;
(
  input  logic signed [SUM_W-1:0] sum_i,
  output logic [PIX_W-1:0]        pix_o
);
  localparam int Q_W = SUM_W - FRAC_W;
  localparam int MAXV = (1 << PIX_W) - 1;

  logic signed [SUM_W-1:0] biased;
  logic signed [Q_W-1:0]   q;

  always_comb begin
    biased = sum_i + $signed(SUM_W'(1) << (FRAC_W - 1));
    q = Q_W'(biased >>> FRAC_W);
    if (q < 0)                pix_o = '0;
    else if (int'(q) > MAXV)  pix_o = '1;
    else                      pix_o = q[PIX_W-1:0];
  end
endmodule

// File: rtl/csc_core.sv
module csc_core
  import csc_pkg::*;
#(
  parameter bit SHARED      = 1'b0,
  parameter int PIPE_STAGES = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NCOMP*PIX_W-1:0] in_pix,
  input  logic                   cfg_wr,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [COEF_W-1:0]      cfg_data,
  output logic                   out_valid,
  output logic [NCOMP*PIX_W-1:0] out_pix
);
  localparam int LATENCY = conv_latency(SHARED, PIPE_STAGES);
  localparam int CNT_W   = $clog2(LATENCY + 2) + 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pix_t    in_c;
  matrix_t active;
  logic    accept, apply;
  sums_t   sum_q, sum_d;
  logic    sum_vld_q, sum_vld_d;

  assign in_c   = in_pix;
  assign accept = in_valid & in_ready;

  csc_coef_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_ni),
    .wr_en    (cfg_wr),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_data),
    .apply    (apply),
    .active_o (active)
  );

  if (!SHARED) begin : g_par
    logic signed [SUM_W-1:0] dot_sum [NCOMP];
    for (genvar k = 0; k < NCOMP; k++) begin : g_lane
      csc_dot u_dot (
        .pix_i (in_c),
        .row_i (active.m[k*NCOMP +: NCOMP]),
        .ofs_i (active.o[k]),
        .sum_o (dot_sum[k])
      );
    end
    always_comb begin
      sum_d = sum_q;
      if (accept)
        for (int k = 0; k < NCOMP; k++) sum_d[k] = dot_sum[k];
      sum_vld_d = accept;
    end
    assign apply    = 1'b1;
    assign in_ready = rst_ni;

    // R5
    par_issue_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      accept |=> sum_vld_q);
  end else begin : g_shr
    logic [PH_W-1:0]         phase_q, phase_d;
    pix_t                    pix_q, pix_d, op_pix;
    coef_t [NCOMP-1:0]       row_sel;
    ofs_t                    ofs_sel;
    logic signed [SUM_W-1:0] dot_sum;
    logic                    step_go;

    always_comb begin
      op_pix  = (phase_q == '0) ? in_c : pix_q;
      row_sel = active.m[0 +: NCOMP];
      ofs_sel = active.o[0];
      for (int r = 1; r < NCOMP; r++)
        if (phase_q == PH_W'(r)) begin
          row_sel = active.m[r*NCOMP +: NCOMP];
          ofs_sel = active.o[r];
        end
    end

    csc_dot u_dot (
      .pix_i (op_pix),
      .row_i (row_sel),
      .ofs_i (ofs_sel),
      .sum_o (dot_sum)
    );

    always_comb begin
      step_go = accept | (phase_q != '0);
      if (phase_q == '0)                   phase_d = accept ? PH_W'(1) : '0;
      else if (phase_q == PH_W'(NCOMP-1)) phase_d = '0;
      else                                 phase_d = phase_q + PH_W'(1);
      pix_d = accept ? in_c : pix_q;
      sum_d = sum_q;
      if (step_go)
        for (int r = 0; r < NCOMP; r++)
          if (phase_q == PH_W'(r)) sum_d[r] = dot_sum;
      sum_vld_d = (phase_q == PH_W'(NCOMP-1));
    end

    assign apply    = (phase_d == '0);
    assign in_ready = rst_ni & (phase_q == '0);

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) phase_q <= '0;
      else         phase_q <= phase_d;
    end
    always_ff @(posedge clk) pix_q <= pix_d;

    // R6
    shared_rhythm_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      accept |=> (!in_ready ##1 !in_ready ##1 in_ready));
    // R7
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      (phase_q != '0) |-> $stable(active));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sum_vld_q <= 1'b0;
    else         sum_vld_q <= sum_vld_d;
  end
  always_ff @(posedge clk) sum_q <= sum_d;

  // optional delay stages between dot products and rounding
  logic  tail_vld;
  sums_t tail_sum;
  if (PIPE_STAGES == 0) begin : g_nopipe
    assign tail_vld = sum_vld_q;
    assign tail_sum = sum_q;
  end else begin : g_pipe
    logic [PIPE_STAGES-1:0] v_q;
    sums_t                  s_q [PIPE_STAGES];
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) v_q <= '0;
      else begin
        v_q[0] <= sum_vld_q;
        for (int i = 1; i < PIPE_STAGES; i++) v_q[i] <= v_q[i-1];
      end
    end
    always_ff @(posedge clk) begin
      s_q[0] <= sum_q;
      for (int i = 1; i < PIPE_STAGES; i++) s_q[i] <= s_q[i-1];
    end
    assign tail_vld = v_q[PIPE_STAGES-1];
    assign tail_sum = s_q[PIPE_STAGES-1];
  end

  pix_t rounded, out_pix_q, out_pix_d;
  logic out_valid_q;
  for (genvar k = 0; k < NCOMP; k++) begin : g_rs
    csc_round_sat u_rs (
      .sum_i (tail_sum[k]),
      .pix_o (rounded[k])
    );
  end

  always_comb begin
    out_pix_d = out_pix_q;
    if (tail_vld) out_pix_d = rounded;
  end
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) out_valid_q <= 1'b0;
    else         out_valid_q <= tail_vld;
  end
  always_ff @(posedge clk) out_pix_q <= out_pix_d;

  assign out_valid = out_valid_q;
  assign out_pix   = out_pix_q;

  // pixels accepted but not yet delivered
  logic [CNT_W-1:0] inflight_q, inflight_d;
  always_comb inflight_d = inflight_q + CNT_W'(accept) - CNT_W'(out_valid_q);
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_d;
  end

  // R8
  out_has_source_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> (inflight_q != '0));
endmodule

// File: tb/csc_core_test.sv
module csc_core_test;
  localparam int P_PIPE = 1;
  localparam int S_PIPE = 2;
  localparam int P_LAT  = 2 + P_PIPE;
  localparam int S_LAT  = 4 + S_PIPE;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        drv_valid, burst;
  logic [23:0] drv_pix;
  logic        cfg_wr;
  logic [3:0]  cfg_addr;
  logic [11:0] cfg_data;
  logic        p_ready, s_ready, p_ov, s_ov;
  logic [23:0] p_out, s_out;
  logic        p_vin, s_vin;

  assign p_vin = burst ? drv_valid : (drv_valid & s_ready);
  assign s_vin = burst ? 1'b0 : drv_valid;

  csc_core #(.SHARED(1'b0), .PIPE_STAGES(P_PIPE)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(p_vin), .in_ready(p_ready), .in_pix(drv_pix),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .out_valid(p_ov), .out_pix(p_out));

  csc_core #(.SHARED(1'b1), .PIPE_STAGES(S_PIPE)) uut_shared (
    .clk(clk), .rst_n(rst_n), .in_valid(s_vin), .in_ready(s_ready), .in_pix(drv_pix),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .out_valid(s_ov), .out_pix(s_out));

  int    mc [12];
  int    cyc = 0;
  int    tests = 0, fails = 0;
  int    since_acc = 100;
  int    p_outs = 0, s_outs = 0, sent = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";
  logic [23:0] p_expq [$];
  logic [23:0] s_expq [$];
  int          p_tq [$];
  int          s_tq [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [23:0] model(input logic [23:0] p);
    logic [23:0] r;
    for (int o = 0; o < 3; o++) begin
      int s = mc[9+o] * 1024 + 512;
      for (int c = 0; c < 3; c++) s += mc[3*o+c] * int'(p[8*c +: 8]);
      s = s >>> 10;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      r[8*o +: 8] = s[7:0];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard and port monitors, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (p_vin && p_ready) begin p_expq.push_back(model(drv_pix)); p_tq.push_back(cyc); end
      if (s_vin && s_ready) begin s_expq.push_back(model(drv_pix)); s_tq.push_back(cyc); sent++; end
      if (burst) check(p_ready == 1'b1, "R5", p_ready, 1);
      if (since_acc < 100) since_acc++;
      if (since_acc == 1 || since_acc == 2) check(s_ready == 1'b0, "R6", s_ready, 0);
      if (since_acc == 3) check(s_ready == 1'b1, "R6", s_ready, 1);
      if (s_vin && s_ready) since_acc = 0;
      if (p_ov) begin
        p_outs++;
        if (p_expq.size() == 0) check(1'b0, "R8", 1, 0);
        else begin
          logic [23:0] e;
          int t;
          e = p_expq.pop_front();
          t = p_tq.pop_front();
          check(p_out == e, cur_req, p_out, e);
          check(cyc - t == P_LAT, "R8", cyc - t, P_LAT);
        end
      end
      if (s_ov) begin
        s_outs++;
        if (s_expq.size() == 0) check(1'b0, "R8", 1, 0);
        else begin
          logic [23:0] e;
          int t;
          e = s_expq.pop_front();
          t = s_tq.pop_front();
          check(s_out == e, cur_req, s_out, e);
          check(cyc - t == S_LAT, "R8", cyc - t, S_LAT);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc == 150000 && !finished) begin
      finished = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic send(input logic [23:0] p);
    drv_pix   = p;
    drv_valid = 1'b1;
    while (!(burst || s_ready)) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    drv_valid = 1'b0;
  endtask

  task automatic wr(input int a, input logic [11:0] d);
    cfg_wr = 1'b1; cfg_addr = 4'(a); cfg_data = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    if (a < 9)       mc[a] = d[11] ? int'(d) - 4096 : int'(d);
    else if (a < 12) mc[a] = d[8] ? int'(d[8:0]) - 512 : int'(d[8:0]);
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    mc = '{306, 601, 117, -173, -339, 512, 512, -429, -83, 0, 128, 128};
    rst_n = 1'b0; drv_valid = 1'b0; burst = 1'b0; drv_pix = '0;
    cfg_wr = 1'b0; cfg_addr = '0; cfg_data = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(p_ov == 1'b0 && s_ov == 1'b0, "R10", {p_ov, s_ov}, 0);
    check(p_ready == 1'b0 && s_ready == 1'b0, "R10", {p_ready, s_ready}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(p_ready == 1'b1 && s_ready == 1'b1, "R10", {p_ready, s_ready}, 3);

    // R1 default matrix over a coarse 3-D sweep, shared rhythm checked alongside (R6)
    cur_req = "R1";
    for (int r = 0; r < 256; r += 15)
      for (int g = 0; g < 256; g += 15)
        for (int b = 0; b < 256; b += 15)
          send({8'(b), 8'(g), 8'(r)});
    repeat (12) @(posedge clk);
    #1;

    // R5 back-to-back stream into the parallel core, general arithmetic R2
    cur_req = "R2";
    burst = 1'b1;
    for (int r = 0; r < 256; r += 15)
      for (int g = 0; g < 256; g += 15)
        for (int b = 0; b < 256; b += 15)
          send({8'(r), 8'(b ^ 8'h33), 8'(g)});
    burst = 1'b0;
    repeat (12) @(posedge clk);
    #1;

    // R3 identity via host writes
    cur_req = "R3";
    for (int a = 0; a < 9; a++) wr(a, (a % 4 == 0) ? 12'd1024 : 12'd0);
    for (int a = 9; a < 12; a++) wr(a, 12'd0);
    for (int i = 0; i < 256; i++) send({8'(i ^ 8'h5A), 8'(255 - i), 8'(i)});
    repeat (12) @(posedge clk);
    #1;

    // R4 writes above the map are ignored: identity must survive
    cur_req = "R4";
    for (int a = 12; a < 16; a++) begin
      cfg_wr = 1'b1; cfg_addr = 4'(a); cfg_data = 12'hFFF;
      @(posedge clk); #1;
      cfg_wr = 1'b0;
    end
    repeat (4) @(posedge clk);
    #1;
    for (int i = 0; i < 64; i++) begin
      send({8'(4 * i), 8'(i), 8'(255 - 4 * i)});
      check(1'b1, "R4", 0, 0);
    end
    repeat (12) @(posedge clk);
    #1;

    // R11 saturation high (row 0), low (row 1), half-up rounding (row 2)
    cur_req = "R11";
    for (int a = 0; a < 3; a++) wr(a, 12'h7FF);
    for (int a = 3; a < 6; a++) wr(a, 12'h800);
    wr(6, 12'd512); wr(7, 12'd0); wr(8, 12'd0);
    wr(9, 12'h0FF); wr(10, 12'h100); wr(11, 12'd0);
    for (int v = 0; v < 256; v++) send({8'(v), 8'(v), 8'(v)});
    repeat (12) @(posedge clk);
    #1;

    // R7 write to a row-2 weight in the same cycle the pixel enters the shared core
    cur_req = "R7";
    drv_pix = {8'd0, 8'd0, 8'd200};
    drv_valid = 1'b1;
    cfg_wr = 1'b1; cfg_addr = 4'd6; cfg_data = 12'hC18;
    @(posedge clk); #1;
    drv_valid = 1'b0; cfg_wr = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    mc[6] = -1000;
    send({8'd0, 8'd0, 8'd200});
    send({8'd7, 8'd90, 8'd255});
    repeat (16) @(posedge clk);
    #1;

    // R8 every accepted pixel delivered; R9 both builds agree in count
    check(p_expq.size() == 0 && s_expq.size() == 0, "R8", p_expq.size() + s_expq.size(), 0);
    check(s_outs == sent, "R9", s_outs, sent);
    check(p_outs == s_outs + 5832, "R9", p_outs, s_outs + 5832);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule